// File: doc/BRIEF.md
# Upstream Read-Frame Serializer

This block sits on the controller-facing side of a buffered memory module. When the local memory returns a 128-bit read word, the block appends a 16-bit CRC to it. It then sends the resulting 144-bit frame toward the controller as six 24-bit beats. The link clock runs six times faster than the memory clock, so one whole frame leaves in exactly one memory-clock period.

Modules farther down the chain also send frames toward the controller, and those frames pass through this block. A free-running six-phase counter defines the frame slots. At each slot boundary the block picks one of three frames:

- the local frame, when local read data is present;
- otherwise, a relayed frame waiting in a one-frame buffer;
- otherwise, an all-zero idle frame.

A relayed frame that loses a boundary to local data waits in the buffer for the next slot. A relayed frame that finds the buffer still occupied is discarded, and a sticky overflow flag records the loss.

Top module: `rd_frame_uplink`

## Requirements
- R1: While `rst_n` is low, `up_beat` is zero, `up_sof` is low and `rly_ovf` is low.
- R2: Slot boundaries fall on the first rising edge after reset is released and on every sixth rising edge after that. `up_sof` is high on exactly the first beat of each slot, one cycle after the boundary edge.
- R3: A local frame leaves as six consecutive beats carrying 18 bytes, most significant byte first. Bytes 0 to 15 are `loc_data[127:120]` down to `loc_data[7:0]`. Bytes 16 and 17 are the CRC high byte and low byte.
- R4: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is fed MSB first over the 16 data bytes, with no reflection and no final XOR.
- R5: `loc_valid` is sampled only at a boundary edge. If it is high at any other edge, it has no effect.
- R6: A relayed frame is six beats on `rly_beat`, with `rly_sof` high on the beat sampled at a boundary edge. It is retransmitted unchanged in the next slot.
- R7: If `rly_sof` is high at an edge that is not a boundary, no frame is captured from the relay input.
- R8: Local data has priority at a boundary. A relayed frame that is waiting at that boundary is kept and sent in the next free slot.
- R9: When a relayed frame completes while the buffer still holds an unsent frame, the new frame is dropped. `rly_ovf` then rises and stays high until reset.
- R10: A slot with nothing to send carries six all-zero beats, and `up_sof` is still high on the first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, six cycles per memory-clock period |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_valid | input | 1 | Local read word present at this boundary |
| loc_data | input | 128 | Local read word, byte 0 in the top bits |
| rly_beat | input | 24 | Relayed beat stream from downstream |
| rly_sof | input | 1 | Marks beat 0 of a relayed frame |
| up_beat | output | 24 | Beat stream toward the controller |
| up_sof | output | 1 | Marks beat 0 of an outgoing frame |
| rly_ovf | output | 1 | Sticky relayed-frame drop flag |

## Verification
A slip in the phase counter shows within one slot: `up_sof` appears off its six-cycle grid, and beats land in the wrong positions. A fault in the buffer occupancy shows two slots after a contested boundary, as a relayed frame that is duplicated, lost, or replaced by idle zeros. The bench therefore checks every beat of every slot rather than only the first. A CRC fault is confined to the final beat of each local frame, so the tests use varied data words, including all-zero and all-ones words.

// File: rtl/upf_pkg.sv
package upf_pkg;
    localparam int unsigned BEAT_W_DEF = 24;
    localparam int unsigned BEATS_DEF  = 6;
    localparam int unsigned DATA_W_DEF = 128;
    localparam int unsigned CRC_W      = 16;

    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_LOCAL = 2'd1,
        SRC_RELAY = 2'd2
    } frame_src_e;
endpackage

// File: rtl/upf_crc16.sv
module upf_crc16 #(
    parameter int unsigned DATA_W = 128,
    parameter logic [15:0] POLY   = 16'h1021,
    parameter logic [15:0] INIT   = 16'hFFFF
) (
    input  logic [DATA_W-1:0] data,
    output logic [15:0]       crc
);
    logic [15:0] acc;
    logic        fb;

    always_comb begin
        acc = INIT;
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[15] ^ data[i];
            acc = {acc[14:0], 1'b0};
            if (fb) acc = acc ^ POLY;
        end
        crc = acc;
    end
endmodule

// File: rtl/upf_relay_buf.sv
module upf_relay_buf #(
    parameter int unsigned BEAT_W = 24,
    parameter int unsigned BEATS  = 6,
    parameter int unsigned PH_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PH_W-1:0]          phase,
    input  logic [BEAT_W-1:0]        rly_beat,
    input  logic                     rly_sof,
    input  logic                     take,
    output logic                     full,
    output logic [BEAT_W*BEATS-1:0]  frame,
    output logic                     ovf
);
    localparam int unsigned FRAME_W = BEAT_W * BEATS;
    localparam int unsigned ASM_W   = BEAT_W * (BEATS - 1);
    localparam logic [PH_W-1:0] LAST = PH_W'(BEATS - 1);

    typedef struct packed {
        logic [ASM_W-1:0]   asm_sh;
        logic               act;
        logic               full;
        logic [FRAME_W-1:0] frm;
        logic               ovf;
    } rb_state_t;

    rb_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.asm_sh = {st_q.asm_sh[ASM_W-BEAT_W-1:0], rly_beat};
        if (phase == '0) st_d.act = rly_sof;
        if (take) st_d.full = 1'b0;
        if (phase == LAST && st_q.act) begin
            if (st_q.full && !take) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.full = 1'b1;
                st_d.frm  = {st_q.asm_sh, rly_beat};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full  = st_q.full;
    assign frame = st_q.frm;
    assign ovf   = st_q.ovf;

    // R8
    drain_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (phase == '0 && st_q.full));

    // R8
    drain_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !st_q.full);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);

    // R9
    ovf_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovf) |-> $past(st_q.full));
endmodule

// File: rtl/rd_frame_uplink.sv
module rd_frame_uplink
    import upf_pkg::*;
#(
    parameter int unsigned BEAT_W   = BEAT_W_DEF,
    parameter int unsigned BEATS    = BEATS_DEF,
    parameter int unsigned DATA_W   = DATA_W_DEF,
    parameter logic [15:0] CRC_POLY = 16'h1021,
    parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_valid,
    input  logic [DATA_W-1:0] loc_data,
    input  logic [BEAT_W-1:0] rly_beat,
    input  logic              rly_sof,
    output logic [BEAT_W-1:0] up_beat,
    output logic              up_sof,
    output logic              rly_ovf
);
    localparam int unsigned FRAME_W = BEAT_W * BEATS;
    localparam int unsigned SH_W    = FRAME_W - BEAT_W;
    localparam int unsigned PH_W    = $clog2(BEATS);
    localparam logic [PH_W-1:0] LAST = PH_W'(BEATS - 1);

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [SH_W-1:0]   sh;
        logic [BEAT_W-1:0] beat;
        logic              sof;
    } ser_state_t;

    ser_state_t         st_d, st_q;
    logic [CRC_W-1:0]   crc;
    logic               buf_full;
    logic [FRAME_W-1:0] buf_frame;
    logic               take;
    frame_src_e         src;
    logic [FRAME_W-1:0] frame_sel;

    upf_crc16 #(
        .DATA_W (DATA_W),
        .POLY   (CRC_POLY),
        .INIT   (CRC_INIT)
    ) u_crc (
        .data (loc_data),
        .crc  (crc)
    );

    upf_relay_buf #(
        .BEAT_W (BEAT_W),
        .BEATS  (BEATS),
        .PH_W   (PH_W)
    ) u_rbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (st_q.phase),
        .rly_beat (rly_beat),
        .rly_sof  (rly_sof),
        .take     (take),
        .full     (buf_full),
        .frame    (buf_frame),
        .ovf      (rly_ovf)
    );

    always_comb begin
        if (loc_valid)     src = SRC_LOCAL;
        else if (buf_full) src = SRC_RELAY;
        else               src = SRC_IDLE;

        case (src)
            SRC_LOCAL: frame_sel = {loc_data, crc};
            SRC_RELAY: frame_sel = buf_frame;
            default:   frame_sel = '0;
        endcase

        take = (st_q.phase == '0) && (src == SRC_RELAY);

        st_d       = st_q;
        st_d.phase = (st_q.phase == LAST) ? '0 : st_q.phase + PH_W'(1);
        if (st_q.phase == '0) begin
            st_d.beat = frame_sel[FRAME_W-1 -: BEAT_W];
            st_d.sh   = frame_sel[SH_W-1:0];
            st_d.sof  = 1'b1;
        end else begin
            st_d.beat = st_q.sh[SH_W-1 -: BEAT_W];
            st_d.sh   = st_q.sh << BEAT_W;
            st_d.sof  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_beat = st_q.beat;
    assign up_sof  = st_q.sof;

    // R2
    sof_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_sof |-> st_q.phase == PH_W'(1));

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase == LAST |=> st_q.phase == '0);

    // R8
    local_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == '0 && loc_valid) |=> up_beat == $past(loc_data[DATA_W-1 -: BEAT_W]));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == '0 && !loc_valid && !buf_full) |=> (up_beat == '0 && up_sof));
endmodule

// File: tb/rd_frame_uplink_bench.sv
module rd_frame_uplink_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         loc_valid;
    logic [127:0] loc_data;
    logic [23:0]  rly_beat;
    logic         rly_sof;
    logic [23:0]  up_beat;
    logic         up_sof;
    logic         rly_ovf;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rd_frame_uplink u_rd_frame_uplink (
        .clk       (clk),
        .rst_n     (rst_n),
        .loc_valid (loc_valid),
        .loc_data  (loc_data),
        .rly_beat  (rly_beat),
        .rly_sof   (rly_sof),
        .up_beat   (up_beat),
        .up_sof    (up_sof),
        .rly_ovf   (rly_ovf)
    );

    typedef struct packed {
        logic         lv;
        logic [2:0]   lph;
        logic [127:0] ld;
    } vec_t;

    // stimulus: local word and the phase at which loc_valid is raised;
    // expected: full frame when the phase is 0, idle frame otherwise
    localparam vec_t VECS [6] = '{
        '{1'b1, 3'd0, 128'h0},
        '{1'b1, 3'd0, {16{8'hFF}}},
        '{1'b1, 3'd0, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF},
        '{1'b1, 3'd0, 128'h8000_0000_0000_0000_0000_0000_0000_0001},
        '{1'b1, 3'd3, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEED_F00D},
        '{1'b1, 3'd5, 128'hA5A5_5A5A_A5A5_5A5A_A5A5_5A5A_A5A5_5A5A}
    };

    function automatic logic [15:0] ref_crc(input logic [127:0] d);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < 16; k++) begin
            c = c ^ {d[127 - 8*k -: 8], 8'h00};
            for (int j = 0; j < 8; j++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    task automatic check(input string tag, input logic [143:0] act, input logic [143:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic slot(input logic lv, input int lph, input logic [127:0] ld,
                        input logic rv, input int rph, input logic [143:0] rf,
                        output logic [143:0] got, output logic [5:0] sofs);
        got  = '0;
        sofs = '0;
        for (int p = 0; p < 6; p++) begin
            loc_valid = lv && (p == lph);
            loc_data  = ld;
            rly_sof   = rv && (p == rph);
            rly_beat  = rv ? rf[143 - 24*p -: 24] : 24'h0;
            @(posedge clk);
            @(negedge clk);
            got  = {got[119:0], up_beat};
            sofs = {sofs[4:0], up_sof};
        end
        loc_valid = 1'b0;
        rly_sof   = 1'b0;
        rly_beat  = '0;
    endtask

    function automatic logic [143:0] lframe(input logic [127:0] d);
        return {d, ref_crc(d)};
    endfunction

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [143:0] got;
        logic [5:0]   sofs;
        logic [143:0] ra, rb, rc, rd, re, rf2;
        ra  = {6{24'h1A2B3C}};
        rb  = 144'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10_1112;
        rc  = 144'hC0C1_C2C3_C4C5_C6C7_C8C9_CACB_CCCD_CECF_D0D1;
        rd  = 144'hD0D0_1111_2222_3333_4444_5555_6666_7777_8888;
        re  = 144'hEEEE_0000_1111_EEEE_0000_1111_EEEE_0000_1111;
        rf2 = 144'hF00F_F00F_F00F_F00F_F00F_F00F_F00F_F00F_F00F;

        rst_n = 1'b0; loc_valid = 1'b0; loc_data = '0; rly_beat = '0; rly_sof = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset up_beat", 144'(up_beat), 144'h0);
        check("R1 reset flags", 144'({up_sof, rly_ovf}), 144'h0);
        rst_n = 1'b1;

        // R10 / R2: idle slot right after reset
        slot(1'b0, 0, '0, 1'b0, 0, '0, got, sofs);
        check("R10 idle frame", got, 144'h0);
        check("R2 sof on beat 0", 144'(sofs), 144'(6'b100000));

        // vector walk: R3 layout, R4 CRC, R5 off-boundary valid ignored
        foreach (VECS[i]) begin
            slot(VECS[i].lv, int'(VECS[i].lph), VECS[i].ld, 1'b0, 0, '0, got, sofs);
            if (VECS[i].lph == 3'd0) begin
                check("R3 local frame", got, lframe(VECS[i].ld));
                check("R4 crc bytes", 144'(got[15:0]), 144'(ref_crc(VECS[i].ld)));
            end else begin
                check("R5 off-boundary valid", got, 144'h0);
            end
            check("R2 sof pattern", 144'(sofs), 144'(6'b100000));
        end
        slot(1'b0, 0, '0, 1'b0, 0, '0, got, sofs);
        check("R5 no late frame", got, 144'h0);

        // R6: relay passes through one slot later
        slot(1'b0, 0, '0, 1'b1, 0, ra, got, sofs);
        check("R6 idle while capturing", got, 144'h0);
        slot(1'b0, 0, '0, 1'b0, 0, '0, got, sofs);
        check("R6 relayed frame", got, ra);

        // R8: local wins, relay held one more slot
        slot(1'b0, 0, '0, 1'b1, 0, rb, got, sofs);
        slot(1'b1, 0, VECS[2].ld, 1'b0, 0, '0, got, sofs);
        check("R8 local first", got, lframe(VECS[2].ld));
        slot(1'b0, 0, '0, 1'b0, 0, '0, got, sofs);
        check("R8 held relay sent", got, rb);
        check("R9 no overflow yet", 144'(rly_ovf), 144'h0);

        // R7: marker off the boundary is ignored
        slot(1'b0, 0, '0, 1'b1, 2, rc, got, sofs);
        slot(1'b0, 0, '0, 1'b0, 0, '0, got, sofs);
        check("R7 misaligned marker", got, 144'h0);

        // R6: back-to-back relays stream through
        slot(1'b0, 0, '0, 1'b1, 0, re, got, sofs);
        slot(1'b0, 0, '0, 1'b1, 0, rf2, got, sofs);
        check("R6 stream first", got, re);
        slot(1'b0, 0, '0, 1'b0, 0, '0, got, sofs);
        check("R6 stream second", got, rf2);

        // R9: overflow drops the second relay
        slot(1'b0, 0, '0, 1'b1, 0, rc, got, sofs);
        slot(1'b1, 0, VECS[3].ld, 1'b1, 0, rd, got, sofs);
        check("R8 local over relay", got, lframe(VECS[3].ld));
        check("R9 overflow set", 144'(rly_ovf), 144'h1);
        slot(1'b0, 0, '0, 1'b0, 0, '0, got, sofs);
        check("R9 buffered frame kept", got, rc);
        slot(1'b0, 0, '0, 1'b0, 0, '0, got, sofs);
        check("R9 dropped frame absent", got, 144'h0);
        check("R9 overflow sticky", 144'(rly_ovf), 144'h1);

        // R1: reset clears the flag
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears overflow", 144'({rly_ovf, up_sof}), 144'h0);
        check("R1 reset clears beat", 144'(up_beat), 144'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule